// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a windowed register file for a processor that makes procedure calls cheap. A logical register number in the range 0 to 25 names either a global register or a register of the current procedure's window. A rotating window pointer maps the number to one entry of a larger physical file. A call moves the pointer forward by one window and a return moves it back. No register contents are copied. The windows of a caller and its callee overlap: the caller's outgoing parameter registers are the callee's incoming ones.

There are eight windows in a ring. The block tracks how many of them currently hold live procedures and how many older windows have been saved to memory. If a call would overrun the ring, the block raises a spill request and stalls until the request is acknowledged. If a return would leave the ring empty while saved windows exist, it raises a fill request and stalls in the same way. The memory transfer itself is done outside the block.

The file has two combinational read ports and one synchronous write port, all addressed by logical number.

Top module: `regwin_file`

## Requirements
- R1: After reset the window pointer `cwp_o` is 0, `stall_o`, `spill_req_o` and `fill_req_o` are low, and every logical register 0 to 31 reads as zero.
- R2: Logical registers 0 to 7 are globals. They name the same storage whatever the window pointer is.
- R3: Logical registers 14 to 19 are locals, private to each window. A value written to a local in one window is not seen at that number in the next window.
- R4: The outgoing registers 20 to 25 of window w are the same storage as the incoming registers 8 to 13 of window w+1. Window 7 wraps to window 0. Physical index = 8 + ((12·w + n − 8) mod 96) for n in 8..25.
- R5: Call and return change only the pointer. Registers written in a window still hold their values after a call and the matching return.
- R6: Both read ports are combinational. A write lands at the clock edge, and a read of the entry being written in that cycle returns the old value.
- R7: Logical numbers 26 to 31 read as zero, and writes to them change no register.
- R8: A call accepted with 7 windows resident raises `spill_req_o` and `stall_o` from the next cycle. They stay high, with the pointer unchanged, until `spill_ack_i` is sampled high. At that edge the pointer advances by one and the request drops.
- R9: A return accepted with 1 window resident and at least one saved window raises `fill_req_o` and `stall_o` until `fill_ack_i` is sampled high. At that edge the pointer steps back by one and the request drops.
- R10: A return with 1 window resident and no saved window is ignored.
- R11: When call and return are both high in the same cycle, both are ignored.
- R12: Call and return are ignored while `stall_o` is high.
- R13: A write in the same cycle as an accepted call or return uses the window that was current before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Procedure call: advance window |
| ret_i | input | 1 | Procedure return: retreat window |
| spill_ack_i | input | 1 | Oldest window has been saved |
| fill_ack_i | input | 1 | Saved window has been restored |
| rd_a_addr_i | input | 5 | Logical number, read port A |
| rd_a_data_o | output | 32 | Read data, port A |
| rd_b_addr_i | input | 5 | Logical number, read port B |
| rd_b_data_o | output | 32 | Read data, port B |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Logical number, write port |
| wr_data_i | input | 32 | Write data |
| spill_req_o | output | 1 | Spill requested |
| fill_req_o | output | 1 | Fill requested |
| stall_o | output | 1 | Call and return are blocked |
| cwp_o | output | 3 | Current window pointer |

## Verification
Read data is due in the same cycle as the address. A write, a pointer move and a raised or dropped request each become visible after exactly one rising edge.

The bench drives every input at the falling edge and compares outputs 1 ns later, before the next rising edge. It then updates its own model of file contents, pointer, resident count and saved count at that rising edge. Every comparison is therefore made against the state that existed before the edge, which is exactly where the design must produce it.

// File: rtl/regwin_file.sv
module regwin_file #(
  parameter int DATA_W = 32,
  parameter int N_WIN  = 8,
  parameter int N_GLB  = 8,
  parameter int N_PAR  = 6,
  parameter int N_LOC  = 6,
  parameter int LR_W   = 5,
  parameter int SAVE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              spill_ack_i,
  input  logic              fill_ack_i,
  input  logic [LR_W-1:0]   rd_a_addr_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [LR_W-1:0]   rd_b_addr_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [LR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              spill_req_o,
  output logic              fill_req_o,
  output logic              stall_o,
  output logic [$clog2(N_WIN)-1:0] cwp_o
);
  localparam int STRIDE  = N_PAR + N_LOC;
  localparam int RING    = N_WIN * STRIDE;
  localparam int N_PHYS  = N_GLB + RING;
  localparam int PHYS_W  = $clog2(N_PHYS);
  localparam int WIN_W   = $clog2(N_WIN);
  localparam int LR_END  = N_GLB + STRIDE + N_PAR;
  localparam int MAX_RES = N_WIN - 1;

  typedef enum logic [1:0] {ST_RUN, ST_SPILL, ST_FILL} st_t;

  st_t                st_q;
  logic [WIN_W-1:0]   cwp_q;
  logic [WIN_W-1:0]   res_q;
  logic [SAVE_W-1:0]  saved_q;
  logic [DATA_W-1:0]  rf [N_PHYS];

  function automatic logic [PHYS_W:0] map_lr(input logic [WIN_W-1:0] w,
                                             input logic [LR_W-1:0] lr);
    int off;
    if (int'(lr) < N_GLB) return {1'b1, PHYS_W'(lr)};
    if (int'(lr) < LR_END) begin
      off = (int'(w) * STRIDE + int'(lr) - N_GLB) % RING;
      return {1'b1, PHYS_W'(N_GLB + off)};
    end
    return '0;
  endfunction

  logic [PHYS_W:0] map_a, map_b, map_w;
  assign map_a = map_lr(cwp_q, rd_a_addr_i);
  assign map_b = map_lr(cwp_q, rd_b_addr_i);
  assign map_w = map_lr(cwp_q, wr_addr_i);

  assign rd_a_data_o = map_a[PHYS_W] ? rf[map_a[PHYS_W-1:0]] : '0;
  assign rd_b_data_o = map_b[PHYS_W] ? rf[map_b[PHYS_W-1:0]] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_PHYS; i++) rf[i] <= '0;
    end else if (wr_en_i && map_w[PHYS_W]) begin
      rf[map_w[PHYS_W-1:0]] <= wr_data_i;
    end
  end

  logic call_ok, ret_ok, at_full, at_last;
  assign call_ok = (st_q == ST_RUN) && call_i && !ret_i;
  assign ret_ok  = (st_q == ST_RUN) && ret_i && !call_i;
  assign at_full = (res_q == WIN_W'(MAX_RES));
  assign at_last = (res_q == WIN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      cwp_q   <= '0;
      res_q   <= WIN_W'(1);
      saved_q <= '0;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (call_ok) begin
            if (at_full) st_q <= ST_SPILL;
            else begin
              cwp_q <= cwp_q + 1'b1;
              res_q <= res_q + 1'b1;
            end
          end else if (ret_ok) begin
            if (at_last) begin
              if (saved_q != '0) st_q <= ST_FILL;
            end else begin
              cwp_q <= cwp_q - 1'b1;
              res_q <= res_q - 1'b1;
            end
          end
        end
        ST_SPILL: if (spill_ack_i) begin
          cwp_q   <= cwp_q + 1'b1;
          saved_q <= saved_q + 1'b1;
          st_q    <= ST_RUN;
        end
        ST_FILL: if (fill_ack_i) begin
          cwp_q   <= cwp_q - 1'b1;
          saved_q <= saved_q - 1'b1;
          st_q    <= ST_RUN;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign spill_req_o = (st_q == ST_SPILL);
  assign fill_req_o  = (st_q == ST_FILL);
  assign stall_o     = (st_q != ST_RUN);
  assign cwp_o       = cwp_q;
endmodule

// File: rtl/regwin_file_chk.sv
module regwin_file_chk #(
  parameter int N_WIN = 8
) (
  input logic clk,
  input logic rst_n,
  input logic call_i,
  input logic ret_i,
  input logic spill_ack_i,
  input logic fill_ack_i,
  input logic spill_req_o,
  input logic fill_req_o,
  input logic stall_o,
  input logic [$clog2(N_WIN)-1:0] cwp_o,
  input logic [$clog2(N_WIN)-1:0] res_q
);
  localparam int WIN_W = $clog2(N_WIN);

  assert_one_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({spill_req_o, fill_req_o}));

  assert_res_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q >= WIN_W'(1)) && (res_q <= WIN_W'(N_WIN - 1)));

  assert_spill_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spill_req_o && !spill_ack_i |=> spill_req_o && stall_o && $stable(cwp_o));

  assert_spill_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spill_req_o && spill_ack_i |=> !spill_req_o && cwp_o == WIN_W'($past(cwp_o) + 1'b1));

  assert_fill_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_o && !fill_ack_i |=> fill_req_o && stall_o && $stable(cwp_o));

  assert_fill_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_o && fill_ack_i |=> !fill_req_o && cwp_o == WIN_W'($past(cwp_o) - 1'b1));

  assert_both_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_o && call_i && ret_i |=> $stable(cwp_o) && !stall_o);
endmodule

bind regwin_file regwin_file_chk #(.N_WIN(N_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
  .spill_ack_i(spill_ack_i), .fill_ack_i(fill_ack_i),
  .spill_req_o(spill_req_o), .fill_req_o(fill_req_o), .stall_o(stall_o),
  .cwp_o(cwp_o), .res_q(res_q)
);

// File: tb/regwin_file_tb_top.sv
`timescale 1ns/1ps
module regwin_file_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic call_i = 0, ret_i = 0, spill_ack_i = 0, fill_ack_i = 0, wr_en_i = 0;
  logic [4:0] rd_a_addr_i = 0, rd_b_addr_i = 0, wr_addr_i = 0;
  logic [31:0] wr_data_i = 0, rd_a_data_o, rd_b_data_o;
  logic spill_req_o, fill_req_o, stall_o;
  logic [2:0] cwp_o;

  always #2.5 clk = ~clk;

  regwin_file dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_rf [104];
  int mcwp = 0, mres = 1, msaved = 0, mst = 0;

  function automatic int mphys(int w, int lr);
    if (lr < 8) return lr;
    if (lr < 26) return 8 + ((w * 12 + lr - 8) % 96);
    return -1;
  endfunction

  function automatic logic [31:0] mread(int lr);
    int p = mphys(mcwp, lr);
    return (p < 0) ? 32'h0 : m_rf[p];
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic op(bit c, bit r, bit we, int wa, logic [31:0] wd,
                    int ra, int rb, bit sa, bit fa, string tag);
    int p;
    @(negedge clk);
    call_i = c; ret_i = r; wr_en_i = we; wr_addr_i = 5'(wa); wr_data_i = wd;
    rd_a_addr_i = 5'(ra); rd_b_addr_i = 5'(rb); spill_ack_i = sa; fill_ack_i = fa;
    #1;
    check(rd_a_data_o === mread(ra), tag, "read A", rd_a_data_o, mread(ra));
    check(rd_b_data_o === mread(rb), tag, "read B", rd_b_data_o, mread(rb));
    check(int'(cwp_o) == mcwp, tag, "cwp", 32'(cwp_o), 32'(mcwp));
    check(spill_req_o === (mst == 1), tag, "spill_req", 32'(spill_req_o), 32'(mst == 1));
    check(fill_req_o === (mst == 2), tag, "fill_req", 32'(fill_req_o), 32'(mst == 2));
    check(stall_o === (mst != 0), tag, "stall", 32'(stall_o), 32'(mst != 0));
    @(posedge clk);
    p = mphys(mcwp, wa);
    if (we && p >= 0) m_rf[p] = wd;
    case (mst)
      0: if (c && !r) begin
           if (mres == 7) mst = 1;
           else begin mcwp = (mcwp + 1) % 8; mres++; end
         end else if (r && !c) begin
           if (mres == 1) begin if (msaved > 0) mst = 2; end
           else begin mcwp = (mcwp + 7) % 8; mres--; end
         end
      1: if (sa) begin mcwp = (mcwp + 1) % 8; msaved++; mst = 0; end
      default: if (fa) begin mcwp = (mcwp + 7) % 8; msaved--; mst = 0; end
    endcase
  endtask

  task automatic rd(int ra, int rb, string tag);
    op(0, 0, 0, 0, 0, ra, rb, 0, 0, tag);
  endtask

  initial begin
    foreach (m_rf[i]) m_rf[i] = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 32; i += 2) rd(i, i + 1, "R1");

    op(0, 0, 1, 14, 32'hA1A1_0001, 14, 3, 0, 0, "R6");
    rd(14, 14, "R6");
    op(0, 0, 1, 3, 32'h6060_0003, 3, 20, 0, 0, "R6");
    op(0, 0, 1, 20, 32'h9A9A_0020, 20, 3, 0, 0, "R6");
    op(1, 0, 1, 15, 32'hC0C0_0015, 15, 20, 0, 0, "R13");
    rd(3, 8, "R2");
    check(rd_a_data_o === 32'h6060_0003, "R2", "global in window 1", rd_a_data_o, 32'h6060_0003);
    check(rd_b_data_o === 32'h9A9A_0020, "R4", "callee in = caller out", rd_b_data_o, 32'h9A9A_0020);
    rd(14, 15, "R3");
    check(rd_a_data_o === 32'h0, "R3", "local private", rd_a_data_o, 32'h0);
    check(rd_b_data_o === 32'h0, "R13", "write at call went to old window", rd_b_data_o, 32'h0);
    op(0, 0, 1, 8, 32'hBEEF_0008, 8, 8, 0, 0, "R4");
    op(0, 1, 0, 0, 0, 8, 14, 0, 0, "R5");
    rd(20, 14, "R5");
    check(rd_a_data_o === 32'hBEEF_0008, "R4", "caller sees callee write", rd_a_data_o, 32'hBEEF_0008);
    check(rd_b_data_o === 32'hA1A1_0001, "R5", "local survives call+return", rd_b_data_o, 32'hA1A1_0001);
    rd(15, 15, "R13");
    check(rd_a_data_o === 32'hC0C0_0015, "R13", "write at call", rd_a_data_o, 32'hC0C0_0015);

    op(0, 0, 1, 27, 32'hDEAD_0027, 27, 31, 0, 0, "R7");
    rd(27, 26, "R7");
    check(rd_a_data_o === 32'h0, "R7", "unmapped number", rd_a_data_o, 32'h0);
    for (int i = 0; i < 26; i += 2) rd(i, i + 1, "R7");

    op(0, 1, 0, 0, 0, 0, 0, 0, 0, "R10");
    rd(0, 0, "R10");
    check(cwp_o === 3'd0 && !stall_o, "R10", "outermost return", 32'(cwp_o), 32'h0);
    op(1, 1, 0, 0, 0, 0, 0, 0, 0, "R11");
    rd(0, 0, "R11");
    check(cwp_o === 3'd0, "R11", "call+return together", 32'(cwp_o), 32'h0);

    for (int k = 0; k < 6; k++)
      op(1, 0, 1, 14, 32'h1100_0000 + 32'(k), 14, 20, 0, 0, "R8");
    op(1, 0, 0, 0, 0, 14, 8, 0, 0, "R8");
    op(1, 0, 0, 0, 0, 14, 8, 0, 0, "R12");
    op(0, 1, 0, 0, 0, 14, 8, 0, 0, "R12");
    check(spill_req_o === 1'b1 && cwp_o === 3'd6, "R8", "spill pending", 32'(cwp_o), 32'h6);
    op(0, 0, 0, 0, 0, 14, 8, 1, 0, "R8");
    rd(14, 8, "R8");
    check(cwp_o === 3'd7 && !spill_req_o, "R8", "spill acked", 32'(cwp_o), 32'h7);
    op(1, 0, 0, 0, 0, 20, 8, 0, 0, "R8");
    op(0, 0, 0, 0, 0, 20, 8, 1, 0, "R8");
    rd(14, 8, "R4");
    check(cwp_o === 3'd0, "R4", "ring wrap", 32'(cwp_o), 32'h0);

    for (int k = 0; k < 6; k++) op(0, 1, 0, 0, 0, 14, 20, 0, 0, "R9");
    op(0, 1, 0, 0, 0, 14, 20, 0, 0, "R9");
    op(0, 1, 0, 0, 0, 14, 20, 0, 0, "R12");
    check(fill_req_o === 1'b1 && stall_o, "R9", "fill pending", 32'(fill_req_o), 32'h1);
    op(0, 0, 0, 0, 0, 14, 20, 0, 1, "R9");
    op(0, 1, 0, 0, 0, 14, 20, 0, 0, "R9");
    op(0, 0, 0, 0, 0, 14, 20, 0, 1, "R9");
    op(0, 1, 0, 0, 0, 14, 20, 0, 0, "R10");
    rd(14, 20, "R10");
    check(cwp_o === 3'd0 && !stall_o, "R10", "no saved windows", 32'(cwp_o), 32'h0);

    for (int k = 0; k < 4000; k++) begin
      int u = int'($urandom % 4);
      bit c = (u == 0) && (msaved < 200);
      op(c, u == 1, $urandom % 2 == 1, int'($urandom % 32), $urandom,
         int'($urandom % 32), int'($urandom % 32),
         $urandom % 3 == 0, $urandom % 3 == 0, "R6");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule